// File: doc/BRIEF.md
# Edge Capture Timer Channel

This block is one counter channel that timestamps transitions on an input line. A free-running up-counter advances on the rising edge of a counter clock. That clock is picked from a set of clock-source lines, can be inverted, and can be ANDed with one of several external gate lines. Two capture registers, first and second, take the counter value on selected edges of the capture input `cap_a`. An edge filter can let only one edge in 2, 4, 8 or 16 through to a load. The first register always loads before the second. A second load into a register that software has not yet read raises an overrun flag.

A trigger sends the counter back to zero on its next counter clock and restarts a clock that was stopped. The trigger can come from software or from a chosen edge of `cap_a` or `cap_b`. The channel can also be set to stop its clock, or to switch it off entirely, when the second register loads. Software sees the channel through a small register port: a write-only command word, a mode word, read-only counter, capture and status words, and an interrupt mask. The status flags clear when the status word is read. The interrupt line is the OR of the enabled flags.

Top module: `capture_timer`

## Requirements
- R1: After reset the counter, both capture registers, the status word and `irq` are 0, and the counter clock is disabled.
- R2: Writing address 0 issues commands: bit 0 enables the counter clock, bit 1 disables it (disable wins when both are set), and bit 2 is a software trigger. Status bit 8 reads 1 while the clock is enabled.
- R3: Mode word (address 1, read/write) bits [2:0] select which `src_clk` line drives the counter, and bit 3 inverts it. Bits [5:4] = 0 leave the clock ungated; a value n from 1 to 3 ANDs it with `gate_in[n-1]`. The counter advances by one on each rising edge of the resulting signal while it runs.
- R4: A trigger (software, or external) makes the next counter clock load 0 instead of incrementing, and clears a stop caused by R9. It does not re-enable a disabled clock. The external trigger edge is mode bits [9:8] (0 none, 1 rising, 2 falling, 3 either). Mode bit 10 picks `cap_a` (0) or `cap_b` (1). An external trigger sets status bit 4.
- R5: Mode bits [12:11] select the `cap_a` edge that loads the first capture register, and bits [14:13] select the edge for the second (same coding as R4). A load stores the current counter value. The first register reads at address 3, the second at address 4. The counter reads at address 2.
- R6: The second register loads only after the first has loaded since the last trigger or second load. While it waits for the first load, edges for the second register have no effect.
- R7: Mode bits [17:15] set subsampling: codes 0, 1, 2, 3, 4 load on every 1st, 2nd, 4th, 8th or 16th qualifying edge, and codes 5 to 7 act as 4. The count restarts after each load and on each trigger.
- R8: Status bit 1 (overrun) sets when a capture register is loaded while its previous value has not yet been read.
- R9: Mode bit 18 stops the counter when the second register loads; the clock stays enabled. Mode bit 19 instead disables the counter clock when the second register loads.
- R10: Status bit 0 sets when the counter wraps from all ones to zero.
- R11: Status bit 2 sets on a first-register load and bit 3 on a second-register load. Reading status (address 5) clears bits [4:0]; an event in the same cycle wins.
- R12: `irq` is high while any status bit [4:0] is set whose bit in the mask word (address 6) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_clk | input | NSRC | Candidate counter clock lines, sampled on `clk` |
| gate_in | input | NGATE | External gate lines |
| cap_a | input | 1 | Capture input, also an external trigger choice |
| cap_b | input | 1 | Alternative external trigger input |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read clears flags) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid in the cycle of `reg_rd` |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench targets the first-then-second load order. A design that let the second register load on its own would overwrite the second value while only second-register edges arrive. Subsampled loads must land on exactly the Nth edge; an off-by-one filter captures one edge early or late, so the stored timestamp is wrong. Overrun is checked both with and without intervening reads. A design that set the flag on every load, or never set it, fails one of the two. The pending zero-load across stop, disable and re-enable is also checked, along with the eight-bit wrap: a design that cleared the pending reset when the clock was disabled, or missed the wrap, reads back a wrong counter value or a missing overflow flag.

// File: rtl/capt_timer_pkg.sv
package capt_timer_pkg;
  // mode word field positions (neighbour logic decodes these)
  localparam int M_SEL_LO   = 0;
  localparam int M_INV      = 3;
  localparam int M_GATE_LO  = 4;
  localparam int M_STOPB    = 18;
  localparam int M_DISB     = 19;
  localparam int M_TEDGE_LO = 8;
  localparam int M_TSRC     = 10;
  localparam int M_AEDGE_LO = 11;
  localparam int M_BEDGE_LO = 13;
  localparam int M_SUB_LO   = 15;
  localparam int MODE_W     = 20;

  localparam logic [2:0] A_CMD = 3'd0, A_MODE = 3'd1, A_CNT = 3'd2,
                         A_CAPA = 3'd3, A_CAPB = 3'd4, A_STAT = 3'd5, A_MASK = 3'd6;

  // edge coding: 0 none, 1 rising, 2 falling, 3 either
  function automatic logic edge_match(input logic [1:0] sel, input logic prev, input logic cur);
    case (sel)
      2'd1:    return !prev && cur;
      2'd2:    return prev && !cur;
      2'd3:    return prev ^ cur;
      default: return 1'b0;
    endcase
  endfunction

  // number of qualifying edges minus one before a load
  function automatic logic [3:0] sub_limit(input logic [2:0] code);
    case (code)
      3'd0:    return 4'd0;
      3'd1:    return 4'd1;
      3'd2:    return 4'd3;
      3'd3:    return 4'd7;
      default: return 4'd15;
    endcase
  endfunction
endpackage

// File: rtl/ct_edge_sel.sv
module ct_edge_sel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sig,
  input  logic [1:0] sel,
  output logic       hit
);
  import capt_timer_pkg::*;
  logic prev_q;
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig;
  end
  assign hit = edge_match(sel, prev_q, sig);
endmodule

// File: rtl/ct_counter.sv
module ct_counter #(
  parameter int CNT_W = 16,
  parameter int NSRC  = 8,
  parameter int NGATE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_clk,
  input  logic [NGATE-1:0] gate_in,
  input  logic [2:0]       src_sel,
  input  logic             src_inv,
  input  logic [1:0]       gate_sel,
  input  logic             run,
  input  logic             trig,
  output logic [CNT_W-1:0] count,
  output logic             tick,
  output logic             pend,
  output logic             ovf_evt
);
  logic raw, gated, prev_q;

  always_comb begin
    raw = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (int'(src_sel) == i) raw = src_clk[i];
    gated = raw ^ src_inv;
    for (int g = 0; g < NGATE; g++)
      if (int'(gate_sel) == g + 1) gated = gated & gate_in[g];
  end

  assign tick    = gated && !prev_q && run;
  assign ovf_evt = tick && !pend && (count == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      count  <= '0;
      pend   <= 1'b0;
    end else begin
      prev_q <= gated;
      if (tick) count <= pend ? '0 : count + 1'b1;
      if (trig)      pend <= 1'b1;
      else if (tick) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/ct_capture.sv
module ct_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_hit,
  input  logic             b_hit,
  input  logic [2:0]       sub_code,
  input  logic             trig,
  input  logic [CNT_W-1:0] count,
  input  logic             a_read,
  input  logic             b_read,
  output logic [CNT_W-1:0] cap_a_q,
  output logic [CNT_W-1:0] cap_b_q,
  output logic             a_load,
  output logic             b_load,
  output logic             a_done,
  output logic             ovr_evt
);
  import capt_timer_pkg::*;
  logic [3:0] sub_q;
  logic       stage_hit, sub_ok, a_unread, b_unread;

  assign stage_hit = a_done ? b_hit : a_hit;
  assign sub_ok    = (sub_q == sub_limit(sub_code));
  assign a_load    = !trig && !a_done && a_hit && sub_ok;
  assign b_load    = !trig && a_done && b_hit && sub_ok;
  assign ovr_evt   = (a_load && a_unread) || (b_load && b_unread);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_q <= '0; a_done <= 1'b0; a_unread <= 1'b0; b_unread <= 1'b0;
      cap_a_q <= '0; cap_b_q <= '0;
    end else begin
      if (trig) begin
        sub_q  <= '0;
        a_done <= 1'b0;
      end else if (stage_hit) begin
        sub_q <= sub_ok ? 4'd0 : sub_q + 4'd1;
        if (sub_ok) a_done <= !a_done;
      end
      if (a_load) cap_a_q <= count;
      if (b_load) cap_b_q <= count;
      a_unread <= a_load || (a_unread && !a_read);
      b_unread <= b_load || (b_unread && !b_read);
    end
  end
endmodule

// File: rtl/capture_timer.sv
module capture_timer #(
  parameter int CNT_W  = 16,
  parameter int NSRC   = 8,
  parameter int NGATE  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_clk,
  input  logic [NGATE-1:0]  gate_in,
  input  logic              cap_a,
  input  logic              cap_b,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  import capt_timer_pkg::*;
  localparam int NFLAG = 5;

  logic [MODE_W-1:0] mode_q;
  logic [NFLAG-1:0]  mask_q, stat_q, stat_ev;
  logic              clk_en, stopped, run;
  logic              cmd_wr, en_cmd, dis_cmd, sw_trig, ext_trig, trig_any;
  logic [CNT_W-1:0]  count, cap_a_q, cap_b_q;
  logic              tick, pend, ovf_evt, ovr_evt, a_load, b_load, a_done;
  logic [1:0]        cap_hit;
  logic              stat_rd;

  assign cmd_wr   = reg_wr && reg_addr == A_CMD;
  assign en_cmd   = cmd_wr && reg_wdata[0];
  assign dis_cmd  = cmd_wr && reg_wdata[1];
  assign sw_trig  = cmd_wr && reg_wdata[2];
  assign trig_any = sw_trig || ext_trig;
  assign run      = clk_en && !stopped;
  assign stat_rd  = reg_rd && reg_addr == A_STAT;

  ct_edge_sel u_trig (
    .clk, .rst_n,
    .sig (mode_q[M_TSRC] ? cap_b : cap_a),
    .sel (mode_q[M_TEDGE_LO +: 2]),
    .hit (ext_trig)
  );

  for (genvar k = 0; k < 2; k++) begin : g_cap_edge
    localparam int LO = (k == 0) ? M_AEDGE_LO : M_BEDGE_LO;
    ct_edge_sel u_edge (
      .clk, .rst_n, .sig(cap_a), .sel(mode_q[LO +: 2]), .hit(cap_hit[k])
    );
  end

  ct_counter #(.CNT_W(CNT_W), .NSRC(NSRC), .NGATE(NGATE)) u_cnt (
    .clk, .rst_n, .src_clk, .gate_in,
    .src_sel (mode_q[M_SEL_LO +: 3]),
    .src_inv (mode_q[M_INV]),
    .gate_sel(mode_q[M_GATE_LO +: 2]),
    .run, .trig(trig_any), .count, .tick, .pend, .ovf_evt
  );

  ct_capture #(.CNT_W(CNT_W)) u_cap (
    .clk, .rst_n,
    .a_hit(cap_hit[0]), .b_hit(cap_hit[1]),
    .sub_code(mode_q[M_SUB_LO +: 3]),
    .trig(trig_any), .count,
    .a_read(reg_rd && reg_addr == A_CAPA),
    .b_read(reg_rd && reg_addr == A_CAPB),
    .cap_a_q, .cap_b_q, .a_load, .b_load, .a_done, .ovr_evt
  );

  assign stat_ev = {ext_trig, b_load, a_load, ovr_evt, ovf_evt};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; mask_q <= '0; stat_q <= '0;
      clk_en <= 1'b0; stopped <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_MODE) mode_q <= reg_wdata[MODE_W-1:0];
      if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata[NFLAG-1:0];
      stat_q <= (stat_rd ? '0 : stat_q) | stat_ev;
      if (dis_cmd || (b_load && mode_q[M_DISB])) clk_en <= 1'b0;
      else if (en_cmd)                           clk_en <= 1'b1;
      if (trig_any)                              stopped <= 1'b0;
      else if (b_load && mode_q[M_STOPB])        stopped <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MODE: reg_rdata = DATA_W'(mode_q);
      A_CNT:  reg_rdata = DATA_W'(count);
      A_CAPA: reg_rdata = DATA_W'(cap_a_q);
      A_CAPB: reg_rdata = DATA_W'(cap_b_q);
      A_STAT: reg_rdata = DATA_W'({clk_en, 3'b000, stat_q});
      A_MASK: reg_rdata = DATA_W'(mask_q);
      default: reg_rdata = '0;
    endcase
  end

  assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/capture_timer_chk.sv
module capture_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tick,
  input logic             pend,
  input logic [CNT_W-1:0] count,
  input logic             a_load,
  input logic             b_load,
  input logic             a_done,
  input logic             ovf_evt,
  input logic [4:0]       stat_q,
  input logic             dis_mode,
  input logic             clk_en
);
  // R3
  halted_counter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count));
  // R4
  trig_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && tick) |=> (count == '0));
  // R6
  load_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_load |-> a_done);
  // R6
  single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_load, b_load}));
  // R10
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> stat_q[0]);
  // R9
  disable_on_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_load && dis_mode) |=> !clk_en);
endmodule

bind capture_timer capture_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk, .rst_n, .run, .tick, .pend, .count, .a_load, .b_load, .a_done,
  .ovf_evt, .stat_q, .dis_mode(mode_q[19]), .clk_en
);

// File: tb/capture_timer_tb.sv
`timescale 1ns/100ps
module capture_timer_tb;
  localparam int CW = 8;
  localparam logic [31:0] BASE = 32'h4800; // first reg rising, second reg falling

  logic        clk = 0, rst_n = 0;
  logic [7:0]  src_clk = '0;
  logic [2:0]  gate_in = '0;
  logic        cap_a = 0, cap_b = 0, reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq;
  int n_chk = 0, n_fail = 0, cycles = 0;

  typedef struct { string req; logic [2:0] addr; logic [31:0] exp; } item_t;
  item_t sb[$];

  capture_timer #(.CNT_W(CW)) u_dut (.*);

  always #2.5 clk = ~clk;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard
  always begin
    @(negedge clk); #1;
    if (reg_rd) begin
      item_t it;
      if (sb.size() == 0) check("SB", 32'hDEAD, 32'h0);
      else begin
        it = sb.pop_front();
        check($sformatf("%s addr%0d", it.req, it.addr), reg_rdata, it.exp);
      end
    end
  end

  task automatic rd(string req, logic [2:0] a, logic [31:0] e);
    item_t it;
    it.req = req; it.addr = a; it.exp = e;
    @(negedge clk);
    sb.push_back(it);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic pulse(int idx, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); src_clk[idx] = 1;
      @(negedge clk); src_clk[idx] = 0;
    end
  endtask

  task automatic set_a(logic v);
    @(negedge clk); cap_a = v;
    @(negedge clk);
  endtask

  task automatic set_b(logic v);
    @(negedge clk); cap_b = v;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd("R1", 3'd2, 0); rd("R1", 3'd5, 0); rd("R1", 3'd3, 0);
    check("R1 irq", irq, 0);

    wr(1, BASE);
    wr(0, 5);                       // enable + software trigger
    pulse(0, 5);                    // first tick loads 0 -> 4
    rd("R4", 3'd2, 4);
    rd("R2", 3'd5, 32'h100);

    // R5 captures
    set_a(1); pulse(0, 3); set_a(0);
    rd("R5", 3'd3, 4); rd("R5", 3'd4, 7);
    rd("R11", 3'd5, 32'h10C); rd("R11", 3'd5, 32'h100);

    // R6 second register waits for first
    wr(1, 32'h3 << 13);
    set_a(1); set_a(0);
    rd("R6", 3'd4, 7); rd("R6", 3'd5, 32'h100);

    // R8 overrun
    wr(1, BASE);
    set_a(1); pulse(0, 1); set_a(0); pulse(0, 1); set_a(1); set_a(0);
    rd("R8", 3'd5, 32'h10E); rd("R8", 3'd3, 9); rd("R8", 3'd4, 9);
    set_a(1); set_a(0);
    rd("R8", 3'd5, 32'h10C); rd("R8", 3'd3, 9); rd("R8", 3'd4, 9);

    // R7 subsample every 2nd edge
    wr(1, BASE | (32'h1 << 15));
    set_a(1); pulse(0, 1); set_a(0); set_a(1);   // RA = 10
    pulse(0, 1); set_a(0); set_a(1); set_a(0);   // RB = 11
    rd("R7", 3'd3, 10); rd("R7", 3'd4, 11); rd("R7", 3'd5, 32'h10C);

    // R4 external trigger on rising cap_b
    wr(1, BASE | (32'h1 << 8) | (32'h1 << 10));
    set_b(1); pulse(0, 3);
    rd("R4", 3'd2, 2); rd("R4", 3'd5, 32'h110);
    set_b(0);

    // R9 stop on second load
    wr(1, BASE | (32'h1 << 18));
    set_a(1); pulse(0, 1); set_a(0); pulse(0, 3);
    rd("R9", 3'd2, 3); rd("R9", 3'd5, 32'h10C);
    rd("R9", 3'd3, 2); rd("R9", 3'd4, 3);
    wr(0, 4); pulse(0, 2);
    rd("R4", 3'd2, 1);

    // R9 disable on second load
    wr(1, BASE | (32'h1 << 19));
    set_a(1); pulse(0, 1); set_a(0);
    rd("R9", 3'd5, 32'h00C);
    wr(0, 4); pulse(0, 2);
    rd("R4", 3'd2, 2); rd("R9", 3'd3, 1); rd("R9", 3'd4, 2);
    wr(0, 1); pulse(0, 2);          // pending zero-load still applies
    rd("R4", 3'd2, 1);

    // R3 source select, invert, gate
    wr(1, BASE | 1);
    pulse(0, 3); pulse(1, 2);
    rd("R3", 3'd2, 3);
    wr(1, BASE | 1 | 8);            // inverted low line rises: +1
    pulse(1, 2);
    rd("R3", 3'd2, 6);
    wr(1, BASE | 1 | 8 | (32'h1 << 4));
    pulse(1, 2);
    rd("R3", 3'd2, 6);
    @(negedge clk); gate_in[0] = 1;
    pulse(1, 1);
    rd("R3", 3'd2, 8);
    wr(1, BASE);

    // R12 interrupt masking
    wr(6, 32'h4);
    check("R12 idle", irq, 0);
    set_a(1);
    check("R12 masked-in", irq, 1);
    rd("R12", 3'd5, 32'h104);
    check("R12 after read", irq, 0);
    set_a(0);
    check("R12 masked-out", irq, 0);
    rd("R12", 3'd5, 32'h108); rd("R5", 3'd3, 8); rd("R5", 3'd4, 8);

    // R10 wrap
    wr(0, 4); pulse(0, 257);
    rd("R10", 3'd2, 0); rd("R10", 3'd5, 32'h101);

    // R2 disable wins over enable
    wr(0, 3);
    rd("R2", 3'd5, 32'h000);

    repeat (4) @(negedge clk);
    check("SB drained", sb.size(), 0);
    finish_run();
  end
endmodule